// File: doc/BRIEF.md
# Legacy Peripheral Address Decoder

This block turns a host I/O cycle into a chip select for one of six legacy devices that share the I/O map of a PC peripheral controller. The six targets are a floppy disk controller, a primary IDE channel, the IDE alternate-status byte, a parallel port and two serial UARTs. Configuration software writes a base-address byte for each device and a few power-down control bytes. The decoder reads those bytes as plain inputs.

Each base byte is converted to an I/O address. The result is compared with the short list of addresses that device may legally occupy. A value that is not on the list is replaced by the device's fixed default, so a bad setting never moves a device to an address it cannot use. A device that is powered down or disabled never receives a select. If two windows overlap, a fixed priority picks the winner, so the selects are always mutually exclusive.

The selects are registered. A strobed address presented before a rising clock edge produces its select just after that edge.

Top module: `legacy_io_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every select output is 0 after that edge.
- R2: Each select is registered. After the rising edge at which `io_strobe` was 1, exactly the winning select is 1. After an edge with `io_strobe` at 0, all selects are 0. Address bits above bit 11 must be zero for any match.
- R3: The floppy base is `cfg_fdc_base[7:2]` times 16. Only 0x3F0 and 0x370 are legal, and any other value decodes as 0x3F0. The window is 8 bytes (base to base+7).
- R4: The IDE base is `cfg_ide_base[7:2]` times 16. Only 0x1F0 and 0x170 are legal, and the default is 0x1F0. The window is 8 bytes.
- R5: The alternate-status address is `cfg_alt_base[7:2]` times 16 plus 6. Only 0x3F6 and 0x376 are legal, and the default is 0x3F6. It decodes a single byte and takes precedence over the floppy window at that byte.
- R6: The parallel base is the whole `cfg_lpt_base` byte times 4. Only 0x3BC, 0x378 and 0x278 are legal, and the default is 0x378. The window is 4 bytes.
- R7: A UART base is bits 7:1 of its byte times 8. Only 0x3F8, 0x2F8, 0x3E8 and 0x2E8 are legal. The default is 0x3F8 for UART A and 0x2F8 for UART B. Each window is 8 bytes.
- R8: Four power-down bits each keep one select at 0. `cfg_pwr_ctl` bit 7 does this for the parallel port, bit 5 for UART A and bit 4 for UART B. `cfg_fdc_ctl` bit 3 does it for the floppy controller.
- R9: A UART whose base byte has bits 7:6 both zero is disabled and never selected.
- R10: When windows overlap, the priority from high to low is alternate-status, floppy, IDE, parallel, UART A, UART B. At most one select is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_strobe | input | 1 | Host I/O cycle qualifier |
| cfg_fdc_base | input | 8 | Floppy base byte |
| cfg_ide_base | input | 8 | IDE base byte |
| cfg_alt_base | input | 8 | Alternate-status base byte |
| cfg_lpt_base | input | 8 | Parallel base byte |
| cfg_uarta_base | input | 8 | UART A base byte |
| cfg_uartb_base | input | 8 | UART B base byte |
| cfg_pwr_ctl | input | 8 | Power-down byte for the parallel port and both UARTs |
| cfg_fdc_ctl | input | 8 | Power-down byte for the floppy controller |
| sel_alt | output | 1 | Alternate-status select |
| sel_fdc | output | 1 | Floppy controller select |
| sel_ide | output | 1 | IDE select |
| sel_lpt | output | 1 | Parallel port select |
| sel_uarta | output | 1 | UART A select |
| sel_uartb | output | 1 | UART B select |

## Verification
The only internal state is the select register. Any wrong internal result shows at the ports one clock after the address that caused it. Such results include a mis-sanitised base, a wrong window width, a dropped power-down term or a priority inversion. A behavioural model checks all six selects together at every step, so each fault appears as a wrong, missing or duplicated select in that same cycle. The stimulus steers each device to every legal address and to illegal values. It also probes the first and last byte of each window and the byte just past it, and it forces overlapping windows so that priority is exercised.

// File: rtl/legacy_dec_pkg.sv
package legacy_dec_pkg;

  localparam int NDEV = 6;
  localparam int LA_W = 12;

  typedef logic [LA_W-1:0] la_t;

  // Device index doubles as priority: lower index wins.
  localparam int D_ALT = 0;
  localparam int D_FDC = 1;
  localparam int D_IDE = 2;
  localparam int D_LPT = 3;
  localparam int D_UA  = 4;
  localparam int D_UB  = 5;

  localparam int MAX_LEGAL = 4;

  function automatic int span_log2(int dev);
    case (dev)
      D_ALT:   return 0;
      D_LPT:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int legal_count(int dev);
    case (dev)
      D_LPT:      return 3;
      D_UA, D_UB: return 4;
      default:    return 2;
    endcase
  endfunction

  function automatic la_t legal_addr(int dev, int k);
    case (dev)
      D_FDC: return (k == 0) ? 12'h3F0 : 12'h370;
      D_IDE: return (k == 0) ? 12'h1F0 : 12'h170;
      D_ALT: return (k == 0) ? 12'h3F6 : 12'h376;
      D_LPT: begin
        case (k)
          0:       return 12'h3BC;
          1:       return 12'h378;
          default: return 12'h278;
        endcase
      end
      default: begin
        case (k)
          0:       return 12'h3F8;
          1:       return 12'h2F8;
          2:       return 12'h3E8;
          default: return 12'h2E8;
        endcase
      end
    endcase
  endfunction

  function automatic la_t default_addr(int dev);
    case (dev)
      D_FDC:   return 12'h3F0;
      D_IDE:   return 12'h1F0;
      D_ALT:   return 12'h3F6;
      D_LPT:   return 12'h378;
      D_UA:    return 12'h3F8;
      default: return 12'h2F8;
    endcase
  endfunction

  function automatic la_t raw_base(int dev, logic [7:0] r);
    case (dev)
      D_FDC, D_IDE: return {2'b00, r[7:2], 4'b0000};
      D_ALT:        return {2'b00, r[7:2], 4'b0110};
      D_LPT:        return {2'b00, r, 2'b00};
      default:      return {2'b00, r[7:1], 3'b000};
    endcase
  endfunction

endpackage

// File: rtl/legacy_base_resolve.sv
module legacy_base_resolve
  import legacy_dec_pkg::*;
#(
  parameter int DEV = D_FDC
) (
  input  logic [7:0] cfg_byte,
  output la_t        base
);

  localparam int NLEGAL = legal_count(DEV);

  la_t raw;

  always_comb begin
    raw  = raw_base(DEV, cfg_byte);
    base = default_addr(DEV);
    for (int k = 0; k < MAX_LEGAL; k++) begin
      if (k < NLEGAL && raw == legal_addr(DEV, k)) base = raw;
    end
  end

endmodule

// File: rtl/legacy_window_hit.sv
module legacy_window_hit #(
  parameter int ADDR_W = 16,
  parameter int LA_W   = 12,
  parameter int SPAN   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LA_W-1:0]   base,
  input  logic              enable,
  output logic              hit
);

  logic [ADDR_W-1:0] base_ext;

  assign base_ext = ADDR_W'(base);
  assign hit      = enable && (addr[ADDR_W-1:SPAN] == base_ext[ADDR_W-1:SPAN]);

endmodule

// File: rtl/legacy_sel_prio.sv
module legacy_sel_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/legacy_io_decoder.sv
module legacy_io_decoder
  import legacy_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_strobe,
  input  logic [7:0]        cfg_fdc_base,
  input  logic [7:0]        cfg_ide_base,
  input  logic [7:0]        cfg_alt_base,
  input  logic [7:0]        cfg_lpt_base,
  input  logic [7:0]        cfg_uarta_base,
  input  logic [7:0]        cfg_uartb_base,
  input  logic [7:0]        cfg_pwr_ctl,
  input  logic [7:0]        cfg_fdc_ctl,
  output logic              sel_alt,
  output logic              sel_fdc,
  output logic              sel_ide,
  output logic              sel_lpt,
  output logic              sel_uarta,
  output logic              sel_uartb
);

  logic [7:0]      base_byte [NDEV];
  logic [NDEV-1:0] dev_en;
  logic [NDEV-1:0] hit;
  logic [NDEV-1:0] gnt;
  logic [NDEV-1:0] sel_q;

  assign base_byte[D_ALT] = cfg_alt_base;
  assign base_byte[D_FDC] = cfg_fdc_base;
  assign base_byte[D_IDE] = cfg_ide_base;
  assign base_byte[D_LPT] = cfg_lpt_base;
  assign base_byte[D_UA]  = cfg_uarta_base;
  assign base_byte[D_UB]  = cfg_uartb_base;

  assign dev_en[D_ALT] = 1'b1;
  assign dev_en[D_FDC] = !cfg_fdc_ctl[3];
  assign dev_en[D_IDE] = 1'b1;
  assign dev_en[D_LPT] = !cfg_pwr_ctl[7];
  assign dev_en[D_UA]  = !cfg_pwr_ctl[5] && (cfg_uarta_base[7:6] != 2'b00);
  assign dev_en[D_UB]  = !cfg_pwr_ctl[4] && (cfg_uartb_base[7:6] != 2'b00);

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    la_t base;

    legacy_base_resolve #(.DEV(g)) u_resolve (
      .cfg_byte (base_byte[g]),
      .base     (base)
    );

    legacy_window_hit #(
      .ADDR_W (ADDR_W),
      .LA_W   (LA_W),
      .SPAN   (span_log2(g))
    ) u_hit (
      .addr   (io_addr),
      .base   (base),
      .enable (dev_en[g]),
      .hit    (hit[g])
    );
  end

  legacy_sel_prio #(.N(NDEV)) u_prio (
    .req (hit),
    .gnt (gnt)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= io_strobe ? gnt : '0;
  end

  assign sel_alt   = sel_q[D_ALT];
  assign sel_fdc   = sel_q[D_FDC];
  assign sel_ide   = sel_q[D_IDE];
  assign sel_lpt   = sel_q[D_LPT];
  assign sel_uarta = sel_q[D_UA];
  assign sel_uartb = sel_q[D_UB];

endmodule

// File: rtl/legacy_io_decoder_chk.sv
module legacy_io_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_strobe,
  input logic [7:0]        cfg_uarta_base,
  input logic [7:0]        cfg_uartb_base,
  input logic [7:0]        cfg_pwr_ctl,
  input logic [7:0]        cfg_fdc_ctl,
  input logic              sel_alt,
  input logic              sel_fdc,
  input logic              sel_ide,
  input logic              sel_lpt,
  input logic              sel_uarta,
  input logic              sel_uartb
);

  logic [5:0] sels;
  assign sels = {sel_uartb, sel_uarta, sel_lpt, sel_ide, sel_fdc, sel_alt};

  a_r10_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sels));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !io_strobe |=> (sels == 6'b0));

  a_r8_lpt_off: assert property (@(posedge clk) disable iff (rst)
    cfg_pwr_ctl[7] |=> !sel_lpt);

  a_r8_uarta_off: assert property (@(posedge clk) disable iff (rst)
    cfg_pwr_ctl[5] |=> !sel_uarta);

  a_r8_uartb_off: assert property (@(posedge clk) disable iff (rst)
    cfg_pwr_ctl[4] |=> !sel_uartb);

  a_r8_fdc_off: assert property (@(posedge clk) disable iff (rst)
    cfg_fdc_ctl[3] |=> !sel_fdc);

  a_r9_uarta_dis: assert property (@(posedge clk) disable iff (rst)
    (cfg_uarta_base[7:6] == 2'b00) |=> !sel_uarta);

  a_r9_uartb_dis: assert property (@(posedge clk) disable iff (rst)
    (cfg_uartb_base[7:6] == 2'b00) |=> !sel_uartb);

  a_r5_alt_byte: assert property (@(posedge clk) disable iff (rst)
    sel_alt |-> ($past(io_addr[3:0]) == 4'h6));

  a_r3_fdc_legal: assert property (@(posedge clk) disable iff (rst)
    sel_fdc |-> ($past(io_addr[ADDR_W-1:3]) == (ADDR_W-3)'(12'h3F0 >> 3) ||
                 $past(io_addr[ADDR_W-1:3]) == (ADDR_W-3)'(12'h370 >> 3)));

endmodule

bind legacy_io_decoder legacy_io_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .io_addr        (io_addr),
  .io_strobe      (io_strobe),
  .cfg_uarta_base (cfg_uarta_base),
  .cfg_uartb_base (cfg_uartb_base),
  .cfg_pwr_ctl    (cfg_pwr_ctl),
  .cfg_fdc_ctl    (cfg_fdc_ctl),
  .sel_alt        (sel_alt),
  .sel_fdc        (sel_fdc),
  .sel_ide        (sel_ide),
  .sel_lpt        (sel_lpt),
  .sel_uarta      (sel_uarta),
  .sel_uartb      (sel_uartb)
);

// File: tb/legacy_io_decoder_test.sv
`timescale 1ns/1ps
module legacy_io_decoder_test;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] io_addr = '0;
  logic              io_strobe = 1'b0;
  logic [7:0] r_fdc, r_ide, r_alt, r_lpt, r_ua, r_ub, r_pwr, r_fctl;
  logic sel_alt, sel_fdc, sel_ide, sel_lpt, sel_uarta, sel_uartb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  legacy_io_decoder #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_strobe(io_strobe),
    .cfg_fdc_base(r_fdc), .cfg_ide_base(r_ide), .cfg_alt_base(r_alt),
    .cfg_lpt_base(r_lpt), .cfg_uarta_base(r_ua), .cfg_uartb_base(r_ub),
    .cfg_pwr_ctl(r_pwr), .cfg_fdc_ctl(r_fctl),
    .sel_alt(sel_alt), .sel_fdc(sel_fdc), .sel_ide(sel_ide),
    .sel_lpt(sel_lpt), .sel_uarta(sel_uarta), .sel_uartb(sel_uartb)
  );

  // Behavioural reference: bit order {uartb, uarta, lpt, ide, fdc, alt}
  function automatic int pick(int dev, int raw);
    int lst[$];
    int dflt;
    case (dev)
      0: begin lst = '{'h3F6, 'h376}; dflt = 'h3F6; end
      1: begin lst = '{'h3F0, 'h370}; dflt = 'h3F0; end
      2: begin lst = '{'h1F0, 'h170}; dflt = 'h1F0; end
      3: begin lst = '{'h3BC, 'h378, 'h278}; dflt = 'h378; end
      4: begin lst = '{'h3F8, 'h2F8, 'h3E8, 'h2E8}; dflt = 'h3F8; end
      default: begin lst = '{'h3F8, 'h2F8, 'h3E8, 'h2E8}; dflt = 'h2F8; end
    endcase
    foreach (lst[i]) if (lst[i] == raw) return raw;
    return dflt;
  endfunction

  function automatic logic [5:0] model(int a, bit stb);
    int base[6];
    int size[6];
    bit en[6];
    base[0] = pick(0, (int'(r_alt) / 4) * 16 + 6);
    base[1] = pick(1, (int'(r_fdc) / 4) * 16);
    base[2] = pick(2, (int'(r_ide) / 4) * 16);
    base[3] = pick(3, int'(r_lpt) * 4);
    base[4] = pick(4, (int'(r_ua) / 2) * 8);
    base[5] = pick(5, (int'(r_ub) / 2) * 8);
    size = '{1, 8, 8, 4, 8, 8};
    en[0] = 1; en[1] = !r_fctl[3]; en[2] = 1; en[3] = !r_pwr[7];
    en[4] = !r_pwr[5] && (r_ua[7:6] != 0);
    en[5] = !r_pwr[4] && (r_ub[7:6] != 0);
    if (!stb) return 6'b0;
    for (int d = 0; d < 6; d++)
      if (en[d] && a >= base[d] && a < base[d] + size[d]) return 6'(1 << d);
    return 6'b0;
  endfunction

  function automatic logic [5:0] seen();
    return {sel_uartb, sel_uarta, sel_lpt, sel_ide, sel_fdc, sel_alt};
  endfunction

  task automatic step(int a, bit stb, string req);
    logic [5:0] exp;
    io_addr = ADDR_W'(a);
    io_strobe = stb;
    exp = model(a, stb);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (seen() !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%b expected=%b", req, a, seen(), exp);
    end
  endtask

  task automatic defaults();
    r_fdc = 8'hFC; r_ide = 8'h7C; r_alt = 8'hFD; r_lpt = 8'hDE;
    r_ua = 8'hFE; r_ub = 8'hBE; r_pwr = 8'h00; r_fctl = 8'h00;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    defaults();
    io_addr = 16'h03F0; io_strobe = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    checks++;
    if (seen() !== 6'b0) begin
      errors++;
      $display("FAIL R1 actual=%b expected=%b", seen(), 6'b0);
    end
    rst = 1'b0;

    // R3 floppy default window
    step('h3F0, 1, "R3"); step('h3F7, 1, "R3"); step('h3F5, 1, "R3");
    // R2 strobe qualification and upper address bits
    step('h3F0, 0, "R2"); step('h13F0, 1, "R2");
    // R5 alternate status precedence
    step('h3F6, 1, "R5");
    // R4 IDE
    step('h1F0, 1, "R4"); step('h1F7, 1, "R4"); step('h1F8, 1, "R4");
    // R6 parallel
    step('h378, 1, "R6"); step('h37B, 1, "R6"); step('h37C, 1, "R6");
    // R7 UARTs at default
    step('h3F8, 1, "R7"); step('h3FF, 1, "R7"); step('h2F8, 1, "R7"); step('h2FF, 1, "R7");

    // R3 remap and illegal fallback
    r_fdc = 8'hDC; step('h370, 1, "R3"); step('h3F0, 1, "R3");
    r_fdc = 8'h10; step('h3F0, 1, "R3"); step('h100, 1, "R3");
    // R4 remap and fallback
    r_ide = 8'h5C; step('h170, 1, "R4"); step('h1F0, 1, "R4");
    r_ide = 8'h00; step('h1F0, 1, "R4"); step('h000, 1, "R4");
    // R5 remap and fallback
    r_alt = 8'hDC; step('h376, 1, "R5"); step('h3F6, 1, "R5"); step('h377, 1, "R5");
    r_alt = 8'h10; step('h3F6, 1, "R5"); step('h106, 1, "R5");
    // R6 all legal bases and fallback
    r_lpt = 8'hEF; step('h3BC, 1, "R6"); step('h3BF, 1, "R6"); step('h378, 1, "R6");
    r_lpt = 8'h9E; step('h278, 1, "R6");
    r_lpt = 8'h12; step('h378, 1, "R6"); step('h048, 1, "R6");
    // R7 alternative UART bases and fallback
    r_ua = 8'hFA; step('h3E8, 1, "R7"); step('h3F8, 1, "R7");
    r_ub = 8'hBA; step('h2E8, 1, "R7"); step('h2F8, 1, "R7");
    r_ua = 8'hC0; step('h3F8, 1, "R7"); step('h300, 1, "R7");
    r_ub = 8'hC0; step('h2F8, 1, "R7");
    defaults();

    // R8 power-down bits
    r_pwr = 8'h80; step('h378, 1, "R8");
    r_pwr = 8'h20; step('h3F8, 1, "R8");
    r_pwr = 8'h10; step('h2F8, 1, "R8");
    r_pwr = 8'h00; r_fctl = 8'h08; step('h3F0, 1, "R8"); step('h3F6, 1, "R8");
    r_fctl = 8'hF7; step('h3F0, 1, "R8");
    defaults();

    // R9 UART disable by zero upper bits
    r_ua = 8'h3F; step('h3F8, 1, "R9"); step('h1F8, 1, "R9");
    r_ub = 8'h3E; step('h2F8, 1, "R9");
    defaults();

    // R10 overlapping UARTs: A beats B
    r_ua = 8'hBE; step('h2F8, 1, "R10"); step('h2FC, 1, "R10");
    r_ub = 8'hFE; r_ua = 8'hFE; step('h3F8, 1, "R10");
    r_pwr = 8'h20; step('h3F8, 1, "R10");
    defaults();

    // R1 reset mid-run clears selects
    rst = 1'b1;
    io_addr = 16'h0378; io_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    checks++;
    if (seen() !== 6'b0) begin
      errors++;
      $display("FAIL R1 actual=%b expected=%b", seen(), 6'b0);
    end
    rst = 1'b0;
    step('h378, 1, "R2");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule